// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multithreaded compute core and decides whether the next thread block from a dispatcher can become resident. Three pools are tracked together: the resident block slots, the number of resident threads, and the register entries of the core's register file. A request carries the number of threads in the block and how many registers each thread needs. The block is admitted whole, or not at all, and only when every pool can hold it.

An admitted block receives a slot number and the base offset of a contiguous register region sized threads times registers-per-thread. The region is found by a first-fit scan over the free space left between resident regions. When a block finishes, the core reports its slot number on a completion port, and the slot, the threads and the register region go back to the pools. A request that does not fit is held at the dispatcher with ready low. It is never dropped and never overtaken, so blocks are admitted strictly in arrival order.

Top module: `tba_admit`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is high, `grant_slot` is the lowest-numbered free slot (binary slot number) and `grant_base` is the register base the block will own.
- R2: No more than 8 blocks are resident at a time. With all 8 slots occupied, `req_ready` is low.
- R3: No more than 768 threads are resident at a time. A request whose thread count exceeds the threads still free gets `req_ready` low, and a request that brings the total to exactly 768 is accepted.
- R4: A block needs `req_threads * req_regs` register entries out of 8192. Its region is the lowest-addressed free stretch of that length, and a block that needs all 8192 entries is accepted on an empty core with base 0.
- R5: Register regions of resident blocks never overlap, and every region ends at or below entry 8192.
- R6: A completion for a resident slot frees its slot, threads and register region. A completion naming a slot that is not resident changes nothing.
- R7: A request with 0 threads or more than 512 threads is never accepted, whatever the core holds.
- R8: A request that does not fit keeps `req_ready` low for as long as it is presented, including when enough register entries are free in total but no single free stretch is long enough.
- R9: A completion takes effect for requests from the following cycle: a request presented in the same cycle as the completion that frees its resources still sees `req_ready` low.
- R10: Synchronous active-low reset empties all slots and returns all threads and register entries to the free pools.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Dispatcher presents a block request |
| req_ready | output | 1 | The presented block fits and is taken at the next edge |
| req_threads | input | 10 | Threads in the requested block |
| req_regs | input | 6 | Registers needed by each thread |
| grant_slot | output | 3 | Slot given to the block, meaningful while `req_ready` is high |
| grant_base | output | 13 | First register entry of the block's region, meaningful while `req_ready` is high |
| done_valid | input | 1 | A resident block has finished |
| done_slot | input | 3 | Slot number of the finished block |

## Verification
The bench drives the register file into a fragmented state where the total free count equals the request's need but no hole is long enough; a design that only checked the free count would accept and hand out an overlapping region. It repeats a completion for a slot already freed, which a design without a residency check would count twice and so later admit a 200-thread block with only 126 threads free. It fills all eight slots with tiny blocks to separate the slot limit from the thread limit, and presents a completion and a request together, where a design that forwarded the release would accept one cycle early. Requests of exactly 8192 entries and exactly 768 threads, and of 0 and 513 threads, probe both sides of each limit.

// File: rtl/tba_pkg.sv
`timescale 1ns/1ps
// Package tba_pkg
// Default configuration of the admission controller: one core's limits.
// Assumes every width elsewhere is derived from these values.
package tba_pkg;
    localparam int DEF_BLOCKS       = 8;
    localparam int DEF_THREADS      = 768;
    localparam int DEF_REG_ENTRIES  = 8192;
    localparam int DEF_BLOCK_THREAD = 512;
    localparam int DEF_RPT_W        = 6;
endpackage

// File: rtl/tba_pool_counter.sv
`timescale 1ns/1ps
// Module tba_pool_counter
// Holds the free amount of one resource pool. Returns and takes may
// happen in the same cycle. Assumes the caller never takes more than
// is free and never returns more than was taken.
module tba_pool_counter #(
    parameter int W    = 10,
    parameter int INIT = 768
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    input  logic         sub_en,
    input  logic [W-1:0] sub_val,
    output logic [W-1:0] count
);
    logic [W-1:0] count_q;
    logic [W-1:0] add_term;
    logic [W-1:0] sub_term;

    // Select the amounts that move this cycle.
    always_comb begin
        add_term = add_en ? add_val : '0;
        sub_term = sub_en ? sub_val : '0;
    end

    // Update the free amount; reset refills the pool.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= W'(INIT);
        else        count_q <= count_q + add_term - sub_term;
    end

    assign count = count_q;
endmodule

// File: rtl/tba_slot_table.sv
`timescale 1ns/1ps
// Module tba_slot_table
// One record per resident block: valid flag, register base, region size
// and thread count. Picks the lowest free slot for the next allocation
// and reports the record of the slot being released. Assumes a release
// only names a valid slot and an allocation only happens when a slot is free.
module tba_slot_table #(
    parameter int NB     = 8,
    parameter int SLOT_W = 3,
    parameter int BASE_W = 13,
    parameter int REG_W  = 14,
    parameter int TCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [BASE_W-1:0] alloc_base,
    input  logic [REG_W-1:0]  alloc_size,
    input  logic [TCNT_W-1:0] alloc_threads,
    input  logic              rel_en,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic [NB-1:0]     slot_valid,
    output logic [BASE_W-1:0] base_arr [NB],
    output logic [REG_W-1:0]  end_arr  [NB],
    output logic              any_free,
    output logic [SLOT_W-1:0] free_slot,
    output logic [TCNT_W-1:0] rel_threads,
    output logic [REG_W-1:0]  rel_size
);
    logic [NB-1:0]     valid_q;
    logic [BASE_W-1:0] base_q [NB];
    logic [REG_W-1:0]  size_q [NB];
    logic [TCNT_W-1:0] thr_q  [NB];

    // Find the lowest-numbered empty slot.
    always_comb begin
        any_free  = 1'b0;
        free_slot = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                any_free  = 1'b1;
                free_slot = SLOT_W'(i);
            end
        end
    end

    // Region end of each slot, used as a first-fit candidate start.
    for (genvar s = 0; s < NB; s++) begin : g_end
        assign end_arr[s]  = REG_W'(base_q[s]) + size_q[s];
        assign base_arr[s] = base_q[s];
    end

    // Write new records and clear released ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NB; i++) begin
                base_q[i] <= '0;
                size_q[i] <= '0;
                thr_q[i]  <= '0;
            end
        end else begin
            if (rel_en) valid_q[rel_slot] <= 1'b0;
            if (alloc_en) begin
                valid_q[free_slot] <= 1'b1;
                base_q[free_slot]  <= alloc_base;
                size_q[free_slot]  <= alloc_size;
                thr_q[free_slot]   <= alloc_threads;
            end
        end
    end

    assign slot_valid  = valid_q;
    assign rel_threads = thr_q[rel_slot];
    assign rel_size    = size_q[rel_slot];
endmodule

// File: rtl/tba_reg_fit.sv
`timescale 1ns/1ps
// Module tba_reg_fit
// First-fit search of the register file. Candidate starts are entry 0
// and the end of every resident region; the lowest candidate whose
// stretch stays in range and overlaps no resident region wins.
// Assumes resident regions never overlap one another.
module tba_reg_fit #(
    parameter int NB          = 8,
    parameter int BASE_W      = 13,
    parameter int REG_W       = 14,
    parameter int NEED_W      = 16,
    parameter int REG_ENTRIES = 8192,
    localparam int SUM_W      = ((NEED_W > REG_W) ? NEED_W : REG_W) + 1
) (
    input  logic [NB-1:0]     slot_valid,
    input  logic [BASE_W-1:0] base_arr [NB],
    input  logic [REG_W-1:0]  end_arr  [NB],
    input  logic [NEED_W-1:0] need,
    output logic              fit,
    output logic [BASE_W-1:0] fit_base
);
    logic [NB:0]      cand_ok;
    logic [REG_W-1:0] cand_start [NB+1];

    for (genvar c = 0; c <= NB; c++) begin : g_cand
        logic             c_valid;
        logic [REG_W-1:0] c_start;
        logic [SUM_W-1:0] c_end;
        logic             c_ok;

        if (c == 0) begin : g_zero
            assign c_valid = 1'b1;
            assign c_start = '0;
        end else begin : g_after
            assign c_valid = slot_valid[c-1];
            assign c_start = end_arr[c-1];
        end

        assign c_end = SUM_W'(c_start) + SUM_W'(need);

        // Test this candidate for range and overlap with every region.
        always_comb begin
            c_ok = c_valid && (c_end <= SUM_W'(REG_ENTRIES));
            for (int j = 0; j < NB; j++) begin
                if (slot_valid[j] &&
                    (SUM_W'(c_start) < SUM_W'(end_arr[j])) &&
                    (SUM_W'(base_arr[j]) < c_end))
                    c_ok = 1'b0;
            end
        end

        assign cand_ok[c]    = c_ok;
        assign cand_start[c] = c_start;
    end

    // Keep the lowest fitting start. A start equal to the top entry can
    // only fit a zero-size block, and start 0 always fits one too, so
    // narrowing to the base width cannot change the winner.
    always_comb begin
        fit      = 1'b0;
        fit_base = '0;
        for (int c = 0; c <= NB; c++) begin
            if (cand_ok[c] && (!fit || BASE_W'(cand_start[c]) < fit_base)) begin
                fit      = 1'b1;
                fit_base = BASE_W'(cand_start[c]);
            end
        end
    end
endmodule

// File: rtl/tba_admit.sv
`timescale 1ns/1ps
// Module tba_admit
// Admits whole thread blocks onto one core when a slot, enough threads
// and a contiguous register region are all free, and returns them on
// completion. Requests that do not fit wait in order with ready low.
// Assumes the dispatcher holds a request until it is taken and that a
// completion is reported once per admitted block.
module tba_admit #(
    parameter int NB                = tba_pkg::DEF_BLOCKS,
    parameter int MAX_THREADS       = tba_pkg::DEF_THREADS,
    parameter int REG_ENTRIES       = tba_pkg::DEF_REG_ENTRIES,
    parameter int MAX_BLOCK_THREADS = tba_pkg::DEF_BLOCK_THREAD,
    parameter int RPT_W             = tba_pkg::DEF_RPT_W,
    localparam int SLOT_W = $clog2(NB),
    localparam int TREQ_W = $clog2(MAX_BLOCK_THREADS) + 1,
    localparam int TCNT_W = $clog2(MAX_THREADS + 1),
    localparam int REG_W  = $clog2(REG_ENTRIES + 1),
    localparam int BASE_W = $clog2(REG_ENTRIES),
    localparam int NEED_W = TREQ_W + RPT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TREQ_W-1:0] req_threads,
    input  logic [RPT_W-1:0]  req_regs,
    output logic [SLOT_W-1:0] grant_slot,
    output logic [BASE_W-1:0] grant_base,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot
);
    logic [NB-1:0]     slot_valid;
    logic [BASE_W-1:0] base_arr [NB];
    logic [REG_W-1:0]  end_arr  [NB];
    logic              any_free;
    logic [SLOT_W-1:0] free_slot;
    logic [TCNT_W-1:0] rel_threads;
    logic [REG_W-1:0]  rel_size;
    logic [TCNT_W-1:0] free_threads;
    logic [REG_W-1:0]  free_regs;
    logic [NEED_W-1:0] need;
    logic              fit;
    logic [BASE_W-1:0] fit_base;
    logic              size_ok, thr_ok, reg_ok;
    logic              accept, release_en;

    // Register demand of the presented block.
    assign need = NEED_W'(req_threads) * NEED_W'(req_regs);

    // Decide whether all three pools can take the block now.
    always_comb begin
        size_ok   = (req_threads != '0) &&
                    (32'(req_threads) <= 32'(MAX_BLOCK_THREADS));
        thr_ok    = 32'(req_threads) <= 32'(free_threads);
        reg_ok    = 32'(need) <= 32'(free_regs);
        req_ready = size_ok && any_free && thr_ok && reg_ok && fit;
    end

    assign accept     = req_valid && req_ready;
    assign release_en = done_valid && slot_valid[done_slot];
    assign grant_slot = free_slot;
    assign grant_base = fit_base;

    tba_slot_table #(
        .NB(NB), .SLOT_W(SLOT_W), .BASE_W(BASE_W), .REG_W(REG_W), .TCNT_W(TCNT_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(accept), .alloc_base(fit_base),
        .alloc_size(REG_W'(need)), .alloc_threads(TCNT_W'(req_threads)),
        .rel_en(release_en), .rel_slot(done_slot),
        .slot_valid(slot_valid), .base_arr(base_arr), .end_arr(end_arr),
        .any_free(any_free), .free_slot(free_slot),
        .rel_threads(rel_threads), .rel_size(rel_size)
    );

    tba_reg_fit #(
        .NB(NB), .BASE_W(BASE_W), .REG_W(REG_W), .NEED_W(NEED_W),
        .REG_ENTRIES(REG_ENTRIES)
    ) u_fit (
        .slot_valid(slot_valid), .base_arr(base_arr), .end_arr(end_arr),
        .need(need), .fit(fit), .fit_base(fit_base)
    );

    tba_pool_counter #(.W(TCNT_W), .INIT(MAX_THREADS)) u_thr_pool (
        .clk(clk), .rst_n(rst_n),
        .add_en(release_en), .add_val(rel_threads),
        .sub_en(accept), .sub_val(TCNT_W'(req_threads)),
        .count(free_threads)
    );

    tba_pool_counter #(.W(REG_W), .INIT(REG_ENTRIES)) u_reg_pool (
        .clk(clk), .rst_n(rst_n),
        .add_en(release_en), .add_val(rel_size),
        .sub_en(accept), .sub_val(REG_W'(need)),
        .count(free_regs)
    );
endmodule

// File: rtl/tba_admit_chk.sv
`timescale 1ns/1ps
// Module tba_admit_chk
// Properties of the admission controller, bound onto tba_admit.
// Assumes it observes the slot bitmap and free-thread count of the top.
module tba_admit_chk #(
    parameter int NB                = 8,
    parameter int MAX_THREADS       = 768,
    parameter int REG_ENTRIES       = 8192,
    parameter int MAX_BLOCK_THREADS = 512,
    parameter int SLOT_W            = 3,
    parameter int TREQ_W            = 10,
    parameter int RPT_W             = 6,
    parameter int TCNT_W            = 10,
    parameter int BASE_W            = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TREQ_W-1:0] req_threads,
    input logic [RPT_W-1:0]  req_regs,
    input logic [SLOT_W-1:0] grant_slot,
    input logic [BASE_W-1:0] grant_base,
    input logic              done_valid,
    input logic [SLOT_W-1:0] done_slot,
    input logic [NB-1:0]     slot_valid,
    input logic [TCNT_W-1:0] free_threads
);
    p_slot_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !slot_valid[grant_slot]);

    p_block_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&slot_valid) |-> !req_ready);

    p_thread_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(free_threads) <= 32'(MAX_THREADS));

    p_reg_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (32'(grant_base) + 32'(req_threads) * 32'(req_regs)
                       <= 32'(REG_ENTRIES)));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && slot_valid[done_slot]) |=> !slot_valid[$past(done_slot)]);

    p_size_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_threads == '0) ||
                       (32'(req_threads) > 32'(MAX_BLOCK_THREADS)))) |-> !req_ready);

    p_slot_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> slot_valid[$past(grant_slot)]);
endmodule

bind tba_admit tba_admit_chk #(
    .NB(NB), .MAX_THREADS(MAX_THREADS), .REG_ENTRIES(REG_ENTRIES),
    .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS), .SLOT_W(SLOT_W), .TREQ_W(TREQ_W),
    .RPT_W(RPT_W), .TCNT_W(TCNT_W), .BASE_W(BASE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_regs(req_regs), .grant_slot(grant_slot),
    .grant_base(grant_base), .done_valid(done_valid), .done_slot(done_slot),
    .slot_valid(slot_valid), .free_threads(free_threads)
);

// File: tb/tba_admit_tb.sv
`timescale 1ns/1ps
// Bench for tba_admit: a vector table walked in order, then directed
// tests for reset, limits and same-cycle release.
module tba_admit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [9:0]  req_threads;
    logic [5:0]  req_regs;
    logic [2:0]  grant_slot;
    logic [12:0] grant_base;
    logic        done_valid;
    logic [2:0]  done_slot;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    tba_admit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_threads(req_threads), .req_regs(req_regs), .grant_slot(grant_slot),
        .grant_base(grant_base), .done_valid(done_valid), .done_slot(done_slot)
    );

    typedef struct packed {
        logic        is_done;
        logic [9:0]  thr;
        logic [5:0]  rpt;
        logic [2:0]  slot;
        logic        exp_rdy;
        logic [2:0]  exp_slot;
        logic [12:0] exp_base;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'd256, 6'd10, 3'd0, 1'b1, 3'd0, 13'd0,    4'd4},  // R4 first block at 0
        '{1'b0, 10'd256, 6'd10, 3'd0, 1'b1, 3'd1, 13'd2560, 4'd4},  // R4 next stretch
        '{1'b0, 10'd256, 6'd11, 3'd0, 1'b1, 3'd2, 13'd5120, 4'd4},  // R4 768 threads reached
        '{1'b0, 10'd1,   6'd0,  3'd0, 1'b0, 3'd0, 13'd0,    4'd3},  // R3 no thread left
        '{1'b1, 10'd0,   6'd0,  3'd1, 1'b0, 3'd0, 13'd0,    4'd6},  // R6 free slot 1
        '{1'b0, 10'd256, 6'd11, 3'd0, 1'b0, 3'd0, 13'd0,    4'd8},  // R8 fragmented
        '{1'b0, 10'd128, 6'd20, 3'd0, 1'b1, 3'd1, 13'd2560, 4'd5},  // R5 exact hole
        '{1'b0, 10'd128, 6'd1,  3'd0, 1'b1, 3'd3, 13'd7936, 4'd4},  // R4 top stretch
        '{1'b1, 10'd0,   6'd0,  3'd0, 1'b0, 3'd0, 13'd0,    4'd6},  // R6 free slot 0
        '{1'b1, 10'd0,   6'd0,  3'd0, 1'b0, 3'd0, 13'd0,    4'd6},  // R6 repeat ignored
        '{1'b0, 10'd64,  6'd0,  3'd0, 1'b1, 3'd0, 13'd0,    4'd1},  // R1 zero regs
        '{1'b0, 10'd64,  6'd40, 3'd0, 1'b1, 3'd4, 13'd0,    4'd4},  // R4 reuse low hole
        '{1'b1, 10'd0,   6'd0,  3'd5, 1'b0, 3'd0, 13'd0,    4'd6},  // R6 idle slot ignored
        '{1'b0, 10'd1,   6'd0,  3'd0, 1'b1, 3'd5, 13'd0,    4'd1},  // R1
        '{1'b0, 10'd1,   6'd0,  3'd0, 1'b1, 3'd6, 13'd0,    4'd1},  // R1
        '{1'b0, 10'd1,   6'd0,  3'd0, 1'b1, 3'd7, 13'd0,    4'd2},  // R2 eighth block
        '{1'b0, 10'd1,   6'd0,  3'd0, 1'b0, 3'd0, 13'd0,    4'd2},  // R2 slots full
        '{1'b1, 10'd0,   6'd0,  3'd6, 1'b0, 3'd0, 13'd0,    4'd6},  // R6 free slot 6
        '{1'b0, 10'd200, 6'd0,  3'd0, 1'b0, 3'd0, 13'd0,    4'd3},  // R3 only 126 free
        '{1'b0, 10'd1,   6'd0,  3'd0, 1'b1, 3'd6, 13'd0,    4'd6}   // R6 slot 6 reused
    };

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check_req(input logic er, input logic [2:0] es,
                             input logic [12:0] eb, input string tag);
        n_chk++;
        if (req_ready !== er || (er && (grant_slot !== es || grant_base !== eb))) begin
            n_bad++;
            $display("FAIL %s: ready/slot/base actual %0b/%0d/%0d expected %0b/%0d/%0d",
                     tag, req_ready, grant_slot, grant_base, er, es, eb);
        end
    endtask

    task automatic drive(input logic rv, input logic [9:0] thr, input logic [5:0] rpt,
                         input logic dv, input logic [2:0] ds);
        @(negedge clk);
        req_valid   = rv;
        req_threads = thr;
        req_regs    = rpt;
        done_valid  = dv;
        done_slot   = ds;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0; done_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1: actual run still busy, expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_threads = '0; req_regs = '0;
        done_valid = 1'b0; done_slot = '0;
        do_reset();

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].is_done) begin
                drive(1'b0, '0, '0, 1'b1, VECS[v].slot);
            end else begin
                drive(1'b1, VECS[v].thr, VECS[v].rpt, 1'b0, '0);
                check_req(VECS[v].exp_rdy, VECS[v].exp_slot, VECS[v].exp_base,
                          $sformatf("R%0d row %0d", VECS[v].rq, v));
            end
        end

        // R10: reset from a loaded state; whole register file on empty core (R4).
        do_reset();
        drive(1'b1, 10'd512, 6'd16, 1'b0, '0);
        check_req(1'b1, 3'd0, 13'd0, "R10 full file after reset");
        // R3: 256 more threads reaches exactly 768.
        drive(1'b1, 10'd256, 6'd0, 1'b0, '0);
        check_req(1'b1, 3'd1, 13'd0, "R3 exact thread limit");
        drive(1'b1, 10'd1, 6'd0, 1'b0, '0);
        check_req(1'b0, 3'd0, 13'd0, "R3 one thread over");

        // R9: release and request together; release counts next cycle.
        drive(1'b1, 10'd512, 6'd0, 1'b1, 3'd0);
        check_req(1'b0, 3'd0, 13'd0, "R9 same-cycle release");
        drive(1'b1, 10'd512, 6'd0, 1'b0, '0);
        check_req(1'b1, 3'd0, 13'd0, "R9 following cycle");

        // R7: illegal sizes on an empty core, held for several cycles (R8).
        do_reset();
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, 10'd513, 6'd0, 1'b0, '0);
            check_req(1'b0, 3'd0, 13'd0, "R7 513 threads");
        end
        drive(1'b1, 10'd0, 6'd1, 1'b0, '0);
        check_req(1'b0, 3'd0, 13'd0, "R7 zero threads");
        drive(1'b1, 10'd1, 6'd1, 1'b0, '0);
        check_req(1'b1, 3'd0, 13'd0, "R8 state untouched by stalled requests");

        drive(1'b0, '0, '0, 1'b0, '0);
        summary();
        $finish;
    end
endmodule